// File: doc/BRIEF.md
# Table-Write Pointer and Staging Bank

This block carries out the table-write operation of a small processor core. When the core presents a valid table-write opcode, the block reads the byte held in the core's table latch. It copies that byte into one of eight byte-wide staging registers, which collect data for a later flash programming pass. The block also moves a 21-bit byte pointer that can address 2 Mbyte. The low two opcode bits choose how the pointer moves: it can stay where it is, step up after the write, step down after the write, or step up before the write. The low three pointer bits choose which staging register is written. No status flags are changed.

An operation lasts two cycles. In the accept cycle the opcode is sampled. In the busy cycle the latch byte is sampled, and the write and any post-update take effect at the end of that cycle. The rest of the core can load the pointer directly, and that load wins over any update the operation makes in the same cycle. A separate clear input sets every staging register back to all ones once a programming pass is finished. The pointer and the whole staging bank are always visible on output ports.

Top module: `tabwrite_unit`

## Requirements
- R1: After reset the pointer is 000000h, `busy` is 0 and every staging byte is FFh.
- R2: An operation starts only when `instr_valid` is 1, `busy` is 0 and `instr_word[15:2]` equals 14'b00000000000011. Any other word, or a strobe while idle without a match, leaves `busy`, the pointer and the bank unchanged.
- R3: An accepted operation makes `busy` 1 for exactly the next cycle. A strobe that arrives while `busy` is 1 is ignored, so an operation never runs twice.
- R4: With `instr_word[1:0]` = 0 the pointer is unchanged, and the byte goes to staging entry pointer[2:0].
- R5: With `instr_word[1:0]` = 1 the byte goes to the entry chosen by the current pointer, and the pointer then steps up by one at the end of the busy cycle. For example, pointer 00A356h and byte 55h give entry 6 = 55h and pointer 00A357h.
- R6: With `instr_word[1:0]` = 2 the byte goes to the entry chosen by the current pointer, and the pointer then steps down by one at the end of the busy cycle.
- R7: With `instr_word[1:0]` = 3 the pointer steps up by one at the accepting edge, and the stepped value chooses the entry. For example, 01389Ah becomes 01389Bh and the byte goes to entry 3.
- R8: Pointer arithmetic wraps modulo 2^21: 1FFFFFh + 1 = 000000h and 000000h - 1 = 1FFFFFh.
- R9: When `ptr_load` is 1 at an edge, the pointer takes `ptr_load_val`, and this wins over any step the operation makes at that same edge. The staging write still uses the pointer as it stood in the busy cycle.
- R10: When `stage_clear` is 1 at an edge, every staging byte becomes FFh, and this wins over a write at the same edge.
- R11: The written byte is the value on `latch_in` during the busy cycle, not during the accept cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Opcode strobe |
| instr_word | input | 16 | Opcode word |
| latch_in | input | 8 | Table latch byte, sampled in the busy cycle |
| ptr_load | input | 1 | Direct pointer load enable |
| ptr_load_val | input | 21 | Value for a direct pointer load |
| stage_clear | input | 1 | Sets all staging bytes to FFh |
| busy | output | 1 | High during the second cycle of an operation |
| ptr_out | output | 21 | Current byte pointer |
| stage_flat | output | 64 | Staging bank, entry k in bits [8k+7:8k] |

## Verification
The checker tests these properties on every cycle: the one-cycle busy pulse, acceptance and rejection by opcode, the pointer movement for each mode, load priority, clear to all ones, and the written byte landing in the entry the pointer chose. Some behaviours need whole sequences and only the bench scenarios reach them. These are the two example operations, wrap-around at both ends of the pointer range, a second strobe held through the busy cycle, a load overlapping each phase of an operation, and a clear that collides with a write. A random run then compares every output with the bench's own model on each clock.

// File: rtl/tw_pkg.sv
package tw_pkg;

    // Pointer movement selected by the low two opcode bits.
    typedef enum logic [1:0] {
        TW_KEEP     = 2'd0,
        TW_POST_INC = 2'd1,
        TW_POST_DEC = 2'd2,
        TW_PRE_INC  = 2'd3
    } tw_mode_e;

    // Upper fourteen opcode bits that identify a table write.
    localparam logic [13:0] TW_OPC_PREFIX = 14'b0000_0000_0000_11;

endpackage

// File: rtl/tw_decode.sv
module tw_decode
    import tw_pkg::*;
(
    input  logic [15:0] word_i,
    output logic        hit_o,
    output tw_mode_e    mode_o
);

    assign hit_o  = (word_i[15:2] == TW_OPC_PREFIX);
    assign mode_o = tw_mode_e'(word_i[1:0]);

endmodule

// File: rtl/tw_ptr_step.sv
module tw_ptr_step #(
    parameter int W = 21
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] inc_o,
    output logic [W-1:0] dec_o
);

    // Natural wrap of W-bit arithmetic gives modulo 2^W behaviour.
    assign inc_o = cur_i + W'(1);
    assign dec_o = cur_i - W'(1);

endmodule

// File: rtl/tw_stage_bank.sv
module tw_stage_bank #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_i,
    input  logic                      wr_en_i,
    input  logic [$clog2(SLOTS)-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    output logic [SLOTS*DATA_W-1:0]   flat_o
);

    localparam int IDX_W = $clog2(SLOTS);
    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] val_d;
        logic [DATA_W-1:0] val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                val_d = wr_data_i;
            end
            if (clear_i) begin
                val_d = ERASED;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= ERASED;
            end else begin
                val_q <= val_d;
            end
        end

        assign flat_o[g*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/tabwrite_unit.sv
module tabwrite_unit
    import tw_pkg::*;
#(
    parameter int PTR_W  = 21,
    parameter int DATA_W = 8,
    parameter int SLOTS  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    instr_valid,
    input  logic [15:0]             instr_word,
    input  logic [DATA_W-1:0]       latch_in,
    input  logic                    ptr_load,
    input  logic [PTR_W-1:0]        ptr_load_val,
    input  logic                    stage_clear,
    output logic                    busy,
    output logic [PTR_W-1:0]        ptr_out,
    output logic [SLOTS*DATA_W-1:0] stage_flat
);

    localparam int IDX_W = $clog2(SLOTS);

    typedef struct packed {
        logic               busy;
        tw_mode_e           mode;
        logic [PTR_W-1:0]   ptr;
    } state_t;

    state_t             st_d;
    state_t             st_q;
    logic               dec_hit;
    tw_mode_e           dec_mode;
    logic [PTR_W-1:0]   ptr_inc;
    logic [PTR_W-1:0]   ptr_dec;
    logic               accept;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;

    tw_decode u_decode (
        .word_i (instr_word),
        .hit_o  (dec_hit),
        .mode_o (dec_mode)
    );

    tw_ptr_step #(.W(PTR_W)) u_step (
        .cur_i (st_q.ptr),
        .inc_o (ptr_inc),
        .dec_o (ptr_dec)
    );

    assign accept = instr_valid && !st_q.busy && dec_hit;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.mode = dec_mode;
            if (dec_mode == TW_PRE_INC) begin
                st_d.ptr = ptr_inc;
            end
        end
        if (st_q.busy) begin
            st_d.busy = 1'b0;
            unique case (st_q.mode)
                TW_POST_INC: st_d.ptr = ptr_inc;
                TW_POST_DEC: st_d.ptr = ptr_dec;
                default:     st_d.ptr = st_q.ptr;
            endcase
        end
        if (ptr_load) begin
            st_d.ptr = ptr_load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, mode: TW_KEEP, ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // The write happens in the busy cycle, indexed by the registered pointer.
    assign wr_en  = st_q.busy;
    assign wr_idx = st_q.ptr[IDX_W-1:0];

    tw_stage_bank #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (stage_clear),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (latch_in),
        .flat_o    (stage_flat)
    );

    assign busy    = st_q.busy;
    assign ptr_out = st_q.ptr;

endmodule

// File: rtl/tw_checker.sv
module tw_checker
    import tw_pkg::*;
#(
    parameter int PTR_W  = 21,
    parameter int DATA_W = 8,
    parameter int SLOTS  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    instr_valid,
    input logic [15:0]             instr_word,
    input logic [DATA_W-1:0]       latch_in,
    input logic                    ptr_load,
    input logic [PTR_W-1:0]        ptr_load_val,
    input logic                    stage_clear,
    input logic                    busy,
    input logic [PTR_W-1:0]        ptr_out,
    input logic [SLOTS*DATA_W-1:0] stage_flat
);

    localparam int IDX_W = $clog2(SLOTS);

    logic               chk_q;
    logic [IDX_W-1:0]   exp_idx_q;
    logic [DATA_W-1:0]  exp_dat_q;
    logic [DATA_W-1:0]  got_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_q     <= 1'b0;
            exp_idx_q <= '0;
            exp_dat_q <= '0;
        end else begin
            chk_q     <= busy && !stage_clear;
            exp_idx_q <= ptr_out[IDX_W-1:0];
            exp_dat_q <= latch_in;
        end
    end

    always_comb got_byte = stage_flat[int'(exp_idx_q)*DATA_W +: DATA_W];

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R3

    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && instr_valid && instr_word[15:2] == TW_OPC_PREFIX) |=> busy); // R2

    AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(instr_valid && instr_word[15:2] == TW_OPC_PREFIX)) |=> !busy); // R2

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> ptr_out == $past(ptr_load_val)); // R9

    AST_KEEP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ptr_load && $past(instr_word[1:0]) == 2'd0) |=> $stable(ptr_out)); // R4

    AST_POST_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ptr_load && $past(instr_word[1:0]) == 2'd1)
            |=> ptr_out == $past(ptr_out) + PTR_W'(1)); // R5

    AST_POST_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ptr_load && $past(instr_word[1:0]) == 2'd2)
            |=> ptr_out == $past(ptr_out) - PTR_W'(1)); // R6

    AST_PRE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && instr_valid && instr_word == 16'h000F && !ptr_load)
            |=> ptr_out == $past(ptr_out) + PTR_W'(1)); // R7

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        stage_clear |=> (&stage_flat)); // R10

    AST_WRITE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q |-> got_byte == exp_dat_q); // R11

endmodule

bind tabwrite_unit tw_checker #(
    .PTR_W  (PTR_W),
    .DATA_W (DATA_W),
    .SLOTS  (SLOTS)
) u_tw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr_word   (instr_word),
    .latch_in     (latch_in),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .stage_clear  (stage_clear),
    .busy         (busy),
    .ptr_out      (ptr_out),
    .stage_flat   (stage_flat)
);

// File: tb/test_tabwrite_unit.sv
module test_tabwrite_unit;

    localparam int PW = 21;
    localparam int DW = 8;
    localparam int NS = 8;
    localparam int PMASK = (1 << PW) - 1;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            instr_valid;
    logic [15:0]     instr_word;
    logic [DW-1:0]   latch_in;
    logic            ptr_load;
    logic [PW-1:0]   ptr_load_val;
    logic            stage_clear;
    logic            busy;
    logic [PW-1:0]   ptr_out;
    logic [NS*DW-1:0] stage_flat;

    always #10 clk = ~clk;

    tabwrite_unit #(.PTR_W(PW), .DATA_W(DW), .SLOTS(NS)) i_tabwrite_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_valid  (instr_valid),
        .instr_word   (instr_word),
        .latch_in     (latch_in),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .stage_clear  (stage_clear),
        .busy         (busy),
        .ptr_out      (ptr_out),
        .stage_flat   (stage_flat)
    );

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc   = 0;
    string cur_req = "R1";

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int byte_at(int k);
        return int'(stage_flat[k*DW +: DW]);
    endfunction

    // Behavioural reference model
    int m_ptr;
    bit m_busy;
    int m_mode;
    int m_st[NS];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr  = 0;
            m_busy = 0;
            m_mode = 0;
            foreach (m_st[k]) m_st[k] = 'hFF;
        end else begin
            int np;
            np = m_ptr;
            if (m_busy) begin
                m_st[m_ptr % NS] = int'(latch_in);
                if (m_mode == 1) np = (m_ptr + 1) & PMASK;
                if (m_mode == 2) np = (m_ptr - 1) & PMASK;
                m_busy = 0;
            end else if (instr_valid === 1'b1 && instr_word[15:2] == 14'h0003) begin
                m_busy = 1;
                m_mode = int'(instr_word[1:0]);
                if (m_mode == 3) np = (m_ptr + 1) & PMASK;
            end
            if (stage_clear === 1'b1) foreach (m_st[k]) m_st[k] = 'hFF;
            if (ptr_load === 1'b1) np = int'(ptr_load_val);
            m_ptr = np;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            chk(cur_req, "model ptr", longint'(ptr_out), longint'(m_ptr));
            chk(cur_req, "model busy", longint'(busy), longint'(m_busy));
            for (int k = 0; k < NS; k++)
                chk(cur_req, $sformatf("model byte %0d", k), byte_at(k), m_st[k]);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL R3 watchdog actual %0d expected below 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // Called at a negedge; returns at the negedge after the load edge.
    task automatic load_ptr(int v);
        ptr_load     = 1'b1;
        ptr_load_val = PW'(v);
        @(negedge clk);
        ptr_load     = 1'b0;
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic issue(logic [1:0] nn, logic [7:0] d, bit hold_strobe);
        instr_valid = 1'b1;
        instr_word  = {14'h0003, nn};
        latch_in    = 8'hEE;
        @(negedge clk);
        chk("R3", "busy in second cycle", longint'(busy), 1);
        instr_valid = hold_strobe;
        latch_in    = d;
        @(negedge clk);
        instr_valid = 1'b0;
        latch_in    = 8'h00;
        chk("R3", "busy after operation", longint'(busy), 0);
    endtask

    initial begin
        rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; latch_in = '0;
        ptr_load = 1'b0; ptr_load_val = '0; stage_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "reset ptr", longint'(ptr_out), 0);
        chk("R1", "reset busy", longint'(busy), 0);
        for (int k = 0; k < NS; k++) chk("R1", "reset byte", byte_at(k), 'hFF);

        cur_req = "R5";
        load_ptr('h00A356);
        issue(2'd1, 8'h55, 1'b0);
        chk("R5", "byte 6", byte_at(6), 'h55);
        chk("R5", "ptr after post-inc", longint'(ptr_out), 'h00A357);
        chk("R11", "latch from busy cycle", byte_at(6), 'h55);

        cur_req = "R4";
        issue(2'd0, 8'h11, 1'b0);
        chk("R4", "ptr kept", longint'(ptr_out), 'h00A357);
        chk("R4", "byte 7", byte_at(7), 'h11);

        cur_req = "R6";
        issue(2'd2, 8'h22, 1'b0);
        chk("R6", "byte 7", byte_at(7), 'h22);
        chk("R6", "ptr after post-dec", longint'(ptr_out), 'h00A356);

        cur_req = "R7";
        load_ptr('h01389A);
        issue(2'd3, 8'h34, 1'b0);
        chk("R7", "ptr after pre-inc", longint'(ptr_out), 'h01389B);
        chk("R7", "byte 3", byte_at(3), 'h34);
        chk("R7", "byte 2 untouched", byte_at(2), 'hFF);

        cur_req = "R8";
        load_ptr('h1FFFFF);
        issue(2'd1, 8'h77, 1'b0);
        chk("R8", "byte 7 at top", byte_at(7), 'h77);
        chk("R8", "wrap up", longint'(ptr_out), 0);
        issue(2'd2, 8'h66, 1'b0);
        chk("R8", "byte 0", byte_at(0), 'h66);
        chk("R8", "wrap down", longint'(ptr_out), 'h1FFFFF);
        issue(2'd3, 8'h99, 1'b0);
        chk("R8", "pre-inc wrap", longint'(ptr_out), 0);
        chk("R8", "byte 0 after pre-inc wrap", byte_at(0), 'h99);

        cur_req = "R2";
        instr_valid = 1'b1; instr_word = 16'h001D; latch_in = 8'h42;
        @(negedge clk);
        instr_word = 16'h800C;
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R2", "no busy on bad opcode", longint'(busy), 0);
        chk("R2", "ptr unchanged", longint'(ptr_out), 0);
        chk("R2", "byte 0 unchanged", byte_at(0), 'h99);
        @(negedge clk);
        chk("R2", "still idle", longint'(busy), 0);

        cur_req = "R3";
        load_ptr('h000010);
        issue(2'd1, 8'hA1, 1'b1);
        chk("R3", "single step despite held strobe", longint'(ptr_out), 'h000011);
        chk("R3", "byte 0 written once", byte_at(0), 'hA1);

        cur_req = "R9";
        instr_valid = 1'b1; instr_word = 16'h000D; latch_in = 8'hEE;
        @(negedge clk);
        instr_valid = 1'b0; latch_in = 8'h5A;
        ptr_load = 1'b1; ptr_load_val = PW'('h000100);
        @(negedge clk);
        ptr_load = 1'b0;
        chk("R9", "load wins post-inc", longint'(ptr_out), 'h000100);
        chk("R9", "write at old ptr", byte_at(1), 'h5A);
        instr_valid = 1'b1; instr_word = 16'h000F; latch_in = 8'hEE;
        ptr_load = 1'b1; ptr_load_val = PW'('h000204);
        @(negedge clk);
        instr_valid = 1'b0; ptr_load = 1'b0; latch_in = 8'h3C;
        chk("R9", "load wins pre-inc", longint'(ptr_out), 'h000204);
        @(negedge clk);
        chk("R9", "write at loaded ptr", byte_at(4), 'h3C);

        cur_req = "R10";
        stage_clear = 1'b1;
        @(negedge clk);
        stage_clear = 1'b0;
        for (int k = 0; k < NS; k++) chk("R10", "cleared byte", byte_at(k), 'hFF);
        instr_valid = 1'b1; instr_word = 16'h000C; latch_in = 8'hEE;
        @(negedge clk);
        instr_valid = 1'b0; latch_in = 8'h01; stage_clear = 1'b1;
        @(negedge clk);
        stage_clear = 1'b0;
        chk("R10", "clear beats write", byte_at(4), 'hFF);

        cur_req = "R11";
        for (int n = 0; n < 600; n++) begin
            instr_valid = ($urandom % 2) == 0;
            if (($urandom % 4) == 0) instr_word = 16'($urandom);
            else instr_word = {14'h0003, 2'($urandom)};
            latch_in    = 8'($urandom);
            ptr_load    = ($urandom % 16) == 0;
            ptr_load_val = (($urandom % 2) == 0) ? PW'(PMASK - ($urandom % 4)) : PW'($urandom);
            stage_clear = ($urandom % 32) == 0;
            @(negedge clk);
        end
        instr_valid = 1'b0; ptr_load = 1'b0; stage_clear = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule